// File: doc/BRIEF.md
# Pointer-Indirect Load/Store Unit

This unit carries out byte loads and stores to a synchronous data memory, with the address taken from one of three 16-bit pointers. Each pointer is a pair of 8-bit general registers. The register file sits outside the unit. The unit receives the selected pointer value and the store data as inputs. It returns two things through writeback ports: the loaded byte, and an updated pointer when the addressing mode changes the pointer.

There are four addressing modes. Plain mode uses the pointer as the address. Post-increment uses the pointer and then advances it by one. Pre-decrement lowers the pointer by one and then uses the new value. Offset mode adds an unsigned 6-bit constant and leaves the pointer as it was. Offset mode is accepted only on the second and third pointers. If it is requested on the first pointer, or if the unused select code is given, the request is refused with an error pulse.

Each accepted access takes two cycles. In the request cycle the memory port is driven directly from the request. In the following cycle the unit is busy, the read byte comes back from memory, and both writebacks are presented.

Top module: `ptr_lsu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `ptrWbEn`, `ldWbEn` and `errPulse` are 0, and `memEn` is 0 while no request is presented.
- R2: In plain mode (`reqMode`=0), `memAddr` equals `ptrVal` and no pointer writeback occurs.
- R3: In post-increment mode (`reqMode`=1), `memAddr` equals `ptrVal`, and in the next cycle `ptrWbVal` = `ptrVal`+1 with `ptrWbEn`=1.
- R4: In pre-decrement mode (`reqMode`=2), `memAddr` equals `ptrVal`-1, and in the next cycle `ptrWbVal` holds that same value with `ptrWbEn`=1.
- R5: In offset mode (`reqMode`=3) on `reqPtr`=1 or 2, `memAddr` = `ptrVal` + zero-extended `reqDisp` (0..63), taken modulo 2^16, and no pointer writeback occurs.
- R6: The pointer select codes map to register pairs as follows: 0 to r27:r26, 1 to r29:r28, 2 to r31:r30. `ptrWbLo` gives the low register number of the selected pair, and the high register is that number plus 1.
- R7: Offset mode with `reqPtr`=0, and any request with `reqPtr`=3, drives no memory access and no writeback. Such a request gives `errPulse`=1 for exactly the next cycle, and the unit stays idle.
- R8: An accepted request drives `memEn`=1 in its own cycle. In the next cycle `busy`=1, and for a load `ldWbEn`=1 with `ldWbReg`=`reqReg` and `ldWbData` equal to the byte stored at `memAddr`.
- R9: A request presented while `busy`=1 is ignored: there is no memory access, and no writeback or error results from it.
- R10: A store (`reqStore`=1) drives `memWe`=1 and `memWdata`=`storeData` in the request cycle, and produces no load writeback.
- R11: Pointer arithmetic wraps across all 16 bits, so a carry or borrow passes between the two bytes: 0x00FF+1 gives 0x0100, 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqPtr | input | 2 | Pointer select (0,1,2; 3 invalid) |
| reqMode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 offset |
| reqDisp | input | 6 | Unsigned offset for mode 3 |
| reqReg | input | 5 | Load destination register |
| ptrVal | input | 16 | Current value of the selected pointer pair |
| storeData | input | 8 | Byte to store |
| busy | output | 1 | Second cycle of an access |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid the cycle after `memEn` |
| ptrWbEn | output | 1 | Pointer writeback strobe |
| ptrWbLo | output | 5 | Low register number of the pair being written |
| ptrWbVal | output | 16 | New pointer value |
| ldWbEn | output | 1 | Load writeback strobe |
| ldWbReg | output | 5 | Load destination register |
| ldWbData | output | 8 | Loaded byte |
| errPulse | output | 1 | Refused request |

## Verification
Every mode is exercised on small pointer values, such as the sequence 0x60, 0x63, 0x62 on the third pointer. These cases show whether the access uses the old or the new pointer, and they also catch a writeback that should not happen. The pointers are then placed on carry and borrow boundaries (0x00FF, 0xFFFF, 0x0000), and offset mode is run at its largest value past 0xFFF0. These cases reveal arithmetic confined to the low byte and offsets that are truncated or sign-extended. Stores are followed by loads from the same address to confirm the write data. Refused combinations, and requests that arrive while the unit is busy, are checked for any memory strobe or writeback they leave behind.

// File: rtl/ptr_lsu_pkg.sv
package ptr_lsu_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_POSTINC = 2'd1,
    MODE_PREDEC  = 2'd2,
    MODE_OFFSET  = 2'd3
  } addrMode_t;

  typedef enum logic [1:0] {
    SEL_X    = 2'd0,
    SEL_Y    = 2'd1,
    SEL_Z    = 2'd2,
    SEL_NONE = 2'd3
  } ptrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic store;
    logic writePtr;
    logic reject;
  } lsuStrobe_t;

endpackage

// File: rtl/ptr_lsu_ctrl.sv
module ptr_lsu_ctrl
  import ptr_lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqStore,
  input  logic [1:0] reqPtr,
  input  logic [1:0] reqMode,
  output lsuStrobe_t strb,
  output logic       busy,
  output logic       ptrWbEn,
  output logic       ldWbEn,
  output logic       errPulse
);

  logic busyR, ptrWbR, ldWbR, errR;
  logic legal, accept;

  always_comb begin
    legal = (reqPtr != SEL_NONE) &&
            !((reqMode == MODE_OFFSET) && (reqPtr == SEL_X));
    accept        = reqValid && !busyR;
    strb.issue    = accept && legal;
    strb.reject   = accept && !legal;
    strb.store    = reqStore;
    strb.writePtr = (reqMode == MODE_POSTINC) || (reqMode == MODE_PREDEC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      ptrWbR <= 1'b0;
      ldWbR  <= 1'b0;
      errR   <= 1'b0;
    end else begin
      busyR  <= strb.issue;
      ptrWbR <= strb.issue && strb.writePtr;
      ldWbR  <= strb.issue && !strb.store;
      errR   <= strb.reject;
    end
  end

  assign busy     = busyR;
  assign ptrWbEn  = ptrWbR;
  assign ldWbEn   = ldWbR;
  assign errPulse = errR;

endmodule

// File: rtl/ptr_lsu_dp.sv
module ptr_lsu_dp
  import ptr_lsu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int DISP_W    = 6,
  parameter int REG_AW    = 5,
  parameter int PAIR_BASE = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        strb,
  input  logic [1:0]        reqPtr,
  input  logic [1:0]        reqMode,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic [REG_AW-1:0] reqReg,
  input  logic [ADDR_W-1:0] ptrVal,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [REG_AW-1:0] ptrWbLo,
  output logic [ADDR_W-1:0] ptrWbVal,
  output logic [REG_AW-1:0] ldWbReg,
  output logic [DATA_W-1:0] ldWbData
);

  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
  localparam logic [REG_AW-1:0] BASE_REG = REG_AW'(PAIR_BASE);

  logic [ADDR_W-1:0] bumped, lowered, offsetAddr, effAddr;
  logic [REG_AW-1:0] loReg;

  always_comb begin
    bumped     = ptrVal + ONE;
    lowered    = ptrVal - ONE;
    offsetAddr = ptrVal + ADDR_W'(reqDisp);
    unique case (addrMode_t'(reqMode))
      MODE_PREDEC: effAddr = lowered;
      MODE_OFFSET: effAddr = offsetAddr;
      default:     effAddr = ptrVal;
    endcase
    loReg = BASE_REG + REG_AW'({reqPtr, 1'b0});
  end

  assign memEn    = strb.issue;
  assign memWe    = strb.issue && strb.store;
  assign memAddr  = effAddr;
  assign memWdata = storeData;
  assign ldWbData = memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrWbLo  <= '0;
      ptrWbVal <= '0;
      ldWbReg  <= '0;
    end else if (strb.issue) begin
      ptrWbLo  <= loReg;
      ptrWbVal <= (reqMode == MODE_POSTINC) ? bumped : lowered;
      ldWbReg  <= reqReg;
    end
  end

endmodule

// File: rtl/ptr_lsu.sv
module ptr_lsu
  import ptr_lsu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int DISP_W    = 6,
  parameter int REG_AW    = 5,
  parameter int PAIR_BASE = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqPtr,
  input  logic [1:0]        reqMode,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic [REG_AW-1:0] reqReg,
  input  logic [ADDR_W-1:0] ptrVal,
  input  logic [DATA_W-1:0] storeData,
  output logic              busy,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ptrWbEn,
  output logic [REG_AW-1:0] ptrWbLo,
  output logic [ADDR_W-1:0] ptrWbVal,
  output logic              ldWbEn,
  output logic [REG_AW-1:0] ldWbReg,
  output logic [DATA_W-1:0] ldWbData,
  output logic              errPulse
);

  lsuStrobe_t strb;

  ptr_lsu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqPtr(reqPtr), .reqMode(reqMode), .strb(strb), .busy(busy),
    .ptrWbEn(ptrWbEn), .ldWbEn(ldWbEn), .errPulse(errPulse)
  );

  ptr_lsu_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W),
    .REG_AW(REG_AW), .PAIR_BASE(PAIR_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqPtr(reqPtr), .reqMode(reqMode),
    .reqDisp(reqDisp), .reqReg(reqReg), .ptrVal(ptrVal), .storeData(storeData),
    .memRdata(memRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .ptrWbLo(ptrWbLo), .ptrWbVal(ptrWbVal),
    .ldWbReg(ldWbReg), .ldWbData(ldWbData)
  );

endmodule

// File: rtl/ptr_lsu_chk.sv
module ptr_lsu_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqStore,
  input logic [1:0]        reqPtr,
  input logic [1:0]        reqMode,
  input logic [ADDR_W-1:0] ptrVal,
  input logic              busy,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              ptrWbEn,
  input logic [ADDR_W-1:0] ptrWbVal,
  input logic              ldWbEn,
  input logic              errPulse
);

  a_r8_busy_follows_issue: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> busy);

  a_r9_no_issue_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !memEn);

  a_r8_load_writes_back: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> ldWbEn);

  a_r10_store_no_load_wb: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> !ldWbEn);

  a_r7_error_no_traffic: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!busy && !ptrWbEn && !ldWbEn));

  a_r7_offset_on_x_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqMode == 2'd3 && reqPtr == 2'd0) |-> !memEn);

  a_r3_postinc_value: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && reqMode == 2'd1) |=> (ptrWbEn && ptrWbVal == $past(memAddr) + 16'd1));

  a_r4_predec_value: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && reqMode == 2'd2) |=> (ptrWbEn && ptrWbVal == $past(memAddr)));

  a_r2_plain_address: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && reqMode == 2'd0) |-> (memAddr == ptrVal));

endmodule

bind ptr_lsu ptr_lsu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
  .reqPtr(reqPtr), .reqMode(reqMode), .ptrVal(ptrVal), .busy(busy),
  .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .ptrWbEn(ptrWbEn),
  .ptrWbVal(ptrWbVal), .ldWbEn(ldWbEn), .errPulse(errPulse)
);

// File: tb/test_ptr_lsu.sv
module test_ptr_lsu;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic        st;
    logic [1:0]  sel;
    logic [1:0]  mode;
    logic [5:0]  disp;
    logic [15:0] init;
    logic [15:0] expAddr;
    logic [15:0] expPtr;
    logic        expWb;
  } vec_t;

  // mode: 0 plain, 1 post-inc, 2 pre-dec, 3 offset
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd2, 2'd1, 6'd0,  16'h0060, 16'h0060, 16'h0061, 1'b1}, // R3
    '{1'b0, 2'd2, 2'd2, 6'd0,  16'h0063, 16'h0062, 16'h0062, 1'b1}, // R4
    '{1'b0, 2'd2, 2'd3, 6'd2,  16'h0062, 16'h0064, 16'h0000, 1'b0}, // R5
    '{1'b0, 2'd0, 2'd0, 6'd0,  16'h1234, 16'h1234, 16'h0000, 1'b0}, // R2
    '{1'b0, 2'd1, 2'd3, 6'd63, 16'hFFF0, 16'h002F, 16'h0000, 1'b0}, // R5 wrap
    '{1'b0, 2'd0, 2'd1, 6'd0,  16'h00FF, 16'h00FF, 16'h0100, 1'b1}, // R11
    '{1'b0, 2'd1, 2'd2, 6'd0,  16'h0000, 16'hFFFF, 16'hFFFF, 1'b1}, // R11
    '{1'b0, 2'd2, 2'd1, 6'd0,  16'hFFFF, 16'hFFFF, 16'h0000, 1'b1}, // R11
    '{1'b1, 2'd1, 2'd0, 6'd0,  16'h0200, 16'h0200, 16'h0000, 1'b0}, // R10
    '{1'b1, 2'd0, 2'd2, 6'd0,  16'h0301, 16'h0300, 16'h0300, 1'b1}  // R10
  };

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqStore;
  logic [1:0] reqPtr, reqMode;
  logic [5:0] reqDisp;
  logic [4:0] reqReg;
  logic [15:0] ptrVal;
  logic [7:0] storeData;
  logic busy, memEn, memWe, ptrWbEn, ldWbEn, errPulse;
  logic [15:0] memAddr, ptrWbVal;
  logic [7:0] memWdata, memRdata, ldWbData;
  logic [4:0] ptrWbLo, ldWbReg;

  logic [7:0] rf [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_lsu i_ptr_lsu (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqPtr(reqPtr), .reqMode(reqMode), .reqDisp(reqDisp), .reqReg(reqReg),
    .ptrVal(ptrVal), .storeData(storeData), .busy(busy), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .ptrWbEn(ptrWbEn), .ptrWbLo(ptrWbLo), .ptrWbVal(ptrWbVal), .ldWbEn(ldWbEn),
    .ldWbReg(ldWbReg), .ldWbData(ldWbData), .errPulse(errPulse)
  );

  // bench register file feeds pointer and store data
  always_comb begin
    if (reqPtr == 2'd3) ptrVal = 16'h0000;
    else ptrVal = {rf[5'd27 + 5'({reqPtr, 1'b0})], rf[5'd26 + 5'({reqPtr, 1'b0})]};
    storeData = rf[reqReg];
  end

  // memory model: pattern plus a few written locations
  function automatic logic [7:0] pattern(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  logic [15:0] wAddr [4];
  logic [7:0]  wData [4];
  logic        wUsed [4];
  int          wCnt;

  function automatic logic [7:0] memRead(logic [15:0] a);
    logic [7:0] v = pattern(a);
    for (int k = 0; k < 4; k++) if (wUsed[k] && wAddr[k] == a) v = wData[k];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      wCnt <= 0;
      for (int k = 0; k < 4; k++) wUsed[k] <= 1'b0;
      memRdata <= 8'h00;
    end else if (memEn) begin
      memRdata <= memRead(memAddr);
      if (memWe) begin
        wAddr[wCnt % 4] <= memAddr;
        wData[wCnt % 4] <= memWdata;
        wUsed[wCnt % 4] <= 1'b1;
        wCnt <= wCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setPtr(input logic [1:0] sel, input logic [15:0] v);
    rf[5'd26 + 5'({sel, 1'b0})] = v[7:0];
    rf[5'd27 + 5'({sel, 1'b0})] = v[15:8];
  endtask

  task automatic doOp(input vec_t v, input logic [4:0] reg_, input logic [7:0] sdata,
                      input string req);
    logic [7:0] expLd;
    @(negedge clk);
    setPtr(v.sel, v.init);
    if (v.st) rf[reg_] = sdata;
    reqStore = v.st; reqPtr = v.sel; reqMode = v.mode; reqDisp = v.disp;
    reqReg = reg_; reqValid = 1'b1;
    #1;
    check(memEn == 1'b1, "R8", "memEn in request cycle", memEn, 1);
    check(memAddr == v.expAddr, req, "memAddr", memAddr, v.expAddr);
    check(memWe == v.st, "R10", "memWe", memWe, v.st);
    if (v.st) check(memWdata == sdata, "R10", "memWdata", memWdata, sdata);
    expLd = memRead(v.expAddr);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R8", "busy after issue", busy, 1);
    check(ptrWbEn == v.expWb, req, "ptrWbEn", ptrWbEn, v.expWb);
    if (v.expWb) begin
      check(ptrWbVal == v.expPtr, req, "ptrWbVal", ptrWbVal, v.expPtr);
      check(ptrWbLo == 5'd26 + 5'({v.sel, 1'b0}), "R6", "ptrWbLo", ptrWbLo,
            26 + 2 * v.sel);
      rf[ptrWbLo] = ptrWbVal[7:0];
      rf[ptrWbLo + 5'd1] = ptrWbVal[15:8];
    end
    check(ldWbEn == !v.st, v.st ? "R10" : "R8", "ldWbEn", ldWbEn, !v.st);
    if (!v.st) begin
      check(ldWbReg == reg_, "R8", "ldWbReg", ldWbReg, reg_);
      check(ldWbData == expLd, "R8", "ldWbData", ldWbData, expLd);
      rf[ldWbReg] = ldWbData;
    end
  endtask

  initial begin
    for (int k = 0; k < 32; k++) rf[k] = 8'(k * 7);
    rstN = 1'b0; reqValid = 1'b0; reqStore = 1'b0; reqPtr = 2'd0;
    reqMode = 2'd0; reqDisp = 6'd0; reqReg = 5'd0;
    repeat (3) @(negedge clk);
    check(busy == 0 && ptrWbEn == 0 && ldWbEn == 0 && errPulse == 0 && memEn == 0,
          "R1", "outputs in reset", {busy, ptrWbEn, ldWbEn, errPulse, memEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && ptrWbEn == 0 && ldWbEn == 0 && errPulse == 0 && memEn == 0,
          "R1", "outputs after reset", {busy, ptrWbEn, ldWbEn, errPulse, memEn}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      case (i)
        0: tag = "R3";  1: tag = "R4";  2: tag = "R5";  3: tag = "R2";
        4: tag = "R5";  5: tag = "R11"; 6: tag = "R11"; 7: tag = "R11";
        default: tag = "R10";
      endcase
      doOp(VECS[i], 5'd5, 8'h3C + 8'(i), tag);
    end

    // R10: store then load back the stored bytes
    doOp('{1'b0, 2'd2, 2'd0, 6'd0, 16'h0200, 16'h0200, 16'h0, 1'b0}, 5'd6, 8'h0, "R10");
    check(rf[6] == 8'h3C + 8'd8, "R10", "readback 0x0200", rf[6], 8'h3C + 8'd8);
    doOp('{1'b0, 2'd1, 2'd3, 6'd5, 16'h02FB, 16'h0300, 16'h0, 1'b0}, 5'd7, 8'h0, "R5");
    check(rf[7] == 8'h3C + 8'd9, "R10", "readback 0x0300", rf[7], 8'h3C + 8'd9);

    // R7: offset on X refused
    @(negedge clk);
    reqStore = 1'b0; reqPtr = 2'd0; reqMode = 2'd3; reqDisp = 6'd4; reqValid = 1'b1;
    #1;
    check(memEn == 1'b0, "R7", "memEn offset on X", memEn, 0);
    @(negedge clk);
    reqValid = 1'b0;
    check(errPulse == 1'b1, "R7", "errPulse offset on X", errPulse, 1);
    check(busy == 0 && ptrWbEn == 0 && ldWbEn == 0, "R7", "no traffic after refusal",
          {busy, ptrWbEn, ldWbEn}, 0);
    @(negedge clk);
    check(errPulse == 1'b0, "R7", "errPulse one cycle", errPulse, 0);

    // R7: select code 3 refused
    reqPtr = 2'd3; reqMode = 2'd1; reqValid = 1'b1;
    #1;
    check(memEn == 1'b0, "R7", "memEn select 3", memEn, 0);
    @(negedge clk);
    reqValid = 1'b0;
    check(errPulse == 1'b1 && ptrWbEn == 0, "R7", "select 3 error",
          {errPulse, ptrWbEn}, 2);

    // R9: request while busy is ignored
    @(negedge clk);
    setPtr(2'd1, 16'h0040);
    reqStore = 1'b0; reqPtr = 2'd1; reqMode = 2'd0; reqReg = 5'd8; reqValid = 1'b1;
    @(negedge clk);
    reqStore = 1'b1; reqPtr = 2'd2; reqMode = 2'd1;
    #1;
    check(memEn == 1'b0, "R9", "memEn while busy", memEn, 0);
    @(negedge clk);
    reqValid = 1'b0;
    check(ptrWbEn == 0 && ldWbEn == 0 && errPulse == 0 && busy == 0, "R9",
          "nothing from ignored request", {ptrWbEn, ldWbEn, errPulse, busy}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule